// File: doc/BRIEF.md
# Event Acceptance and Vector Selection

This block sits beside a core's execute stage and decides, every cycle, whether an event is taken and which 8-bit vector the core dispatches. Four sources compete for service. The first is a synchronous exception reported by execute as a 3-bit cause code. The second is a software interrupt instruction that carries its own vector. The third is a non-maskable interrupt input. The fourth is a maskable request that comes with an external vector.

The decision is combinational within the cycle. The block also produces an error-code-valid flag, an event class and an acknowledge for the maskable source. It keeps two pieces of state. One is the interrupt-enable flag. The other is a non-maskable tracker that latches rising edges and blocks all events while a non-maskable handler runs. The core supplies the gate type of the vector being entered, and the enable flag changes on entry according to that gate type. The flag is also driven by set and clear commands and restored on interrupt return.

Top module: `evt_select`

## Requirements
- R1: After reset, `ie_o` is 0, no event is taken, and no non-maskable handler is marked active.
- R2: An exception cause maps to a fixed vector and class. Cause 0 gives 0, 1 gives 6, 2 gives 11, 3 gives 12, 4 gives 13, 5 gives 14 and 6 gives 18, all with class fault (`cls_o`=2'b00). Cause 7 gives vector 3 with class trap (2'b01).
- R3: `err_valid_o` is 1 only when a taken exception has vector 11, 12, 13 or 14.
- R4: A software interrupt is taken with its own vector, which may be any value from 0 to 255, and with class trap (2'b01).
- R5: When several events are pending in the same cycle, the exception is served first, then the software interrupt, then the non-maskable event, then the maskable request.
- R6: The maskable request is taken only when `ie_o` is 1 and `boundary_i` is 1. When taken, `vec_o` equals `intr_vec_i`, `cls_o` is interrupt (2'b10) and `intr_ack_o` is 1.
- R7: A rising edge on `nmi_i` is latched and becomes pending one cycle later. It is taken regardless of `ie_o`, with vector 2 and class interrupt (2'b10).
- R8: From the cycle after a non-maskable event is taken until the cycle after `iret_i`, no event of any source is taken. A second rising edge that arrives in that window stays pending and is taken afterwards.
- R9: `sti_i` sets `ie_o` to 1 on the next cycle and `cli_i` clears it.
- R10: Taking an event with `gate_trap_i`=0 clears `ie_o` on the next cycle. Taking one with `gate_trap_i`=1 leaves it unchanged.
- R11: `iret_i` loads `ie_o` from `iret_if_i`. The precedence for the flag is: entry through a gate that clears it, then `iret_i`, then `sti_i`, then `cli_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary; maskable sampling point |
| exc_valid_i | input | 1 | Synchronous exception pending |
| exc_cause_i | input | 3 | Exception cause code |
| swi_valid_i | input | 1 | Software interrupt instruction |
| swi_vec_i | input | 8 | Vector named by the instruction |
| nmi_i | input | 1 | Non-maskable interrupt line |
| intr_i | input | 1 | Maskable request |
| intr_vec_i | input | 8 | External vector for the maskable request |
| gate_trap_i | input | 1 | Gate type of the entered vector: 1 trap, 0 interrupt |
| sti_i | input | 1 | Set enable flag command |
| cli_i | input | 1 | Clear enable flag command |
| iret_i | input | 1 | Interrupt return |
| iret_if_i | input | 1 | Enable bit from the saved flags word |
| take_o | output | 1 | An event is taken this cycle |
| vec_o | output | 8 | Vector of the taken event |
| err_valid_o | output | 1 | Error code accompanies the event |
| cls_o | output | 2 | 00 fault, 01 trap, 10 interrupt |
| intr_ack_o | output | 1 | Maskable request accepted |
| ie_o | output | 1 | Current interrupt-enable flag |

## Verification
The checker watches several behaviours on every cycle. It holds the maskable acknowledge to the enable flag and the boundary, and requires the external vector to pass through unchanged. It allows no take while a non-maskable handler is active, and restricts the error flag to the four vectors. It also checks each flag update: set, gate entry and return. The bench scenarios cover the rest. Those are the full cause-to-vector table, the priority among simultaneous sources, the one-cycle latching of a non-maskable edge, a second edge held pending across the handler and then served, and precedence when a return and a set command arrive together.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int EXC_W = 3;
  localparam int SRC_N = 4;
  localparam int SRC_EXC  = 0;
  localparam int SRC_SWI  = 1;
  localparam int SRC_NMI  = 2;
  localparam int SRC_INTR = 3;

  typedef enum logic [1:0] {
    CLS_FAULT = 2'b00,
    CLS_TRAP  = 2'b01,
    CLS_INTR  = 2'b10
  } evt_cls_e;

  typedef enum logic [EXC_W-1:0] {
    EXC_DIV = 3'd0,
    EXC_UD  = 3'd1,
    EXC_NP  = 3'd2,
    EXC_SS  = 3'd3,
    EXC_GP  = 3'd4,
    EXC_PF  = 3'd5,
    EXC_MC  = 3'd6,
    EXC_BP  = 3'd7
  } exc_cause_e;

  localparam logic [7:0] NMI_VEC = 8'd2;

  function automatic logic [7:0] exc_vec(exc_cause_e c);
    case (c)
      EXC_DIV: exc_vec = 8'd0;
      EXC_UD:  exc_vec = 8'd6;
      EXC_NP:  exc_vec = 8'd11;
      EXC_SS:  exc_vec = 8'd12;
      EXC_GP:  exc_vec = 8'd13;
      EXC_PF:  exc_vec = 8'd14;
      EXC_MC:  exc_vec = 8'd18;
      default: exc_vec = 8'd3;
    endcase
  endfunction

  function automatic logic exc_has_err(exc_cause_e c);
    exc_has_err = (c == EXC_NP) || (c == EXC_SS) || (c == EXC_GP) || (c == EXC_PF);
  endfunction
endpackage

// File: rtl/evt_ie_flag.sv
module evt_ie_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic gate_trap_i,
  input  logic iret_i,
  input  logic iret_if_i,
  input  logic sti_i,
  input  logic cli_i,
  output logic ie_o
);
  logic ie_q, ie_d;

  always_comb begin
    ie_d = ie_q;
    if (take_i && !gate_trap_i) ie_d = 1'b0;
    else if (iret_i)            ie_d = iret_if_i;
    else if (sti_i)             ie_d = 1'b1;
    else if (cli_i)             ie_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= 1'b0;
    else         ie_q <= ie_d;
  end

  assign ie_o = ie_q;
endmodule

// File: rtl/evt_nmi_track.sv
module evt_nmi_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_nmi_i,
  input  logic iret_i,
  output logic pend_o,
  output logic busy_o
);
  logic nmi_q, pend_q, busy_q;
  logic rise;

  assign rise = nmi_i && !nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= (pend_q && !take_nmi_i) || rise;
      if (take_nmi_i)  busy_q <= 1'b1;
      else if (iret_i) busy_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/evt_prio.sv
module evt_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  // lower index wins
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]   = req_i[i] && !seen[i];
    assign seen[i+1]  = seen[i] || req_i[i];
  end
endmodule

// File: rtl/evt_select.sv
module evt_select
  import evt_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic             exc_valid_i,
  input  logic [EXC_W-1:0] exc_cause_i,
  input  logic             swi_valid_i,
  input  logic [VEC_W-1:0] swi_vec_i,
  input  logic             nmi_i,
  input  logic             intr_i,
  input  logic [VEC_W-1:0] intr_vec_i,
  input  logic             gate_trap_i,
  input  logic             sti_i,
  input  logic             cli_i,
  input  logic             iret_i,
  input  logic             iret_if_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             err_valid_o,
  output logic [1:0]       cls_o,
  output logic             intr_ack_o,
  output logic             ie_o
);
  logic             ie, nmi_pend, nmi_busy;
  logic [SRC_N-1:0] req, gnt;
  exc_cause_e       cause;

  assign cause = exc_cause_e'(exc_cause_i);

  always_comb begin
    req           = '0;
    req[SRC_EXC]  = exc_valid_i;
    req[SRC_SWI]  = swi_valid_i;
    req[SRC_NMI]  = nmi_pend;
    req[SRC_INTR] = intr_i && ie && boundary_i;
    if (nmi_busy) req = '0;
  end

  evt_prio #(.N(SRC_N)) u_prio (
    .req_i (req),
    .gnt_o (gnt)
  );

  evt_nmi_track u_nmi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nmi_i      (nmi_i),
    .take_nmi_i (gnt[SRC_NMI]),
    .iret_i     (iret_i),
    .pend_o     (nmi_pend),
    .busy_o     (nmi_busy)
  );

  evt_ie_flag u_ie (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take_o),
    .gate_trap_i (gate_trap_i),
    .iret_i      (iret_i),
    .iret_if_i   (iret_if_i),
    .sti_i       (sti_i),
    .cli_i       (cli_i),
    .ie_o        (ie)
  );

  always_comb begin
    vec_o       = '0;
    err_valid_o = 1'b0;
    cls_o       = CLS_FAULT;
    unique case (1'b1)
      gnt[SRC_EXC]: begin
        vec_o       = VEC_W'(exc_vec(cause));
        err_valid_o = exc_has_err(cause);
        cls_o       = (cause == EXC_BP) ? CLS_TRAP : CLS_FAULT;
      end
      gnt[SRC_SWI]: begin
        vec_o = swi_vec_i;
        cls_o = CLS_TRAP;
      end
      gnt[SRC_NMI]: begin
        vec_o = VEC_W'(NMI_VEC);
        cls_o = CLS_INTR;
      end
      gnt[SRC_INTR]: begin
        vec_o = intr_vec_i;
        cls_o = CLS_INTR;
      end
      default: ;
    endcase
  end

  assign take_o     = |gnt;
  assign intr_ack_o = gnt[SRC_INTR];
  assign ie_o       = ie;
endmodule

// File: rtl/evt_select_chk.sv
module evt_select_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             boundary_i,
  input logic             intr_i,
  input logic [VEC_W-1:0] intr_vec_i,
  input logic             gate_trap_i,
  input logic             sti_i,
  input logic             cli_i,
  input logic             iret_i,
  input logic             iret_if_i,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             err_valid_o,
  input logic             intr_ack_o,
  input logic             ie_o,
  input logic             nmi_busy
);
  a_r1_reset_ie: assert property (@(posedge clk_i) !rst_ni |=> !ie_o);

  a_r3_err_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> take_o && vec_o >= VEC_W'(11) && vec_o <= VEC_W'(14));

  a_r6_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_ack_o |-> ie_o && boundary_i && intr_i && take_o);

  a_r6_ext_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_ack_o |-> vec_o == intr_vec_i);

  a_r8_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_busy |-> !take_o);

  a_r9_sti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sti_i && !take_o && !iret_i |=> ie_o);

  a_r9_cli: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cli_i && !sti_i && !take_o && !iret_i |=> !ie_o);

  a_r10_int_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !gate_trap_i |=> !ie_o);

  a_r10_trap_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && gate_trap_i && !iret_i && !sti_i && !cli_i |=> $stable(ie_o));

  a_r11_iret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iret_i && !(take_o && !gate_trap_i) |=> ie_o == $past(iret_if_i));
endmodule

bind evt_select evt_select_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .boundary_i  (boundary_i),
  .intr_i      (intr_i),
  .intr_vec_i  (intr_vec_i),
  .gate_trap_i (gate_trap_i),
  .sti_i       (sti_i),
  .cli_i       (cli_i),
  .iret_i      (iret_i),
  .iret_if_i   (iret_if_i),
  .take_o      (take_o),
  .vec_o       (vec_o),
  .err_valid_o (err_valid_o),
  .intr_ack_o  (intr_ack_o),
  .ie_o        (ie_o),
  .nmi_busy    (nmi_busy)
);

// File: tb/evt_select_tb_top.sv
`timescale 1ns/1ps
module evt_select_tb_top;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          boundary, exc_v, swi_v, nmi, intr, gate_trap, sti, cli, iret, iret_if;
  logic [2:0]    exc_c;
  logic [VW-1:0] swi_vec, intr_vec;
  logic          take, err_v, ack, ie;
  logic [VW-1:0] vec;
  logic [1:0]    cls;

  evt_select #(.VEC_W(VW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary),
    .exc_valid_i(exc_v), .exc_cause_i(exc_c),
    .swi_valid_i(swi_v), .swi_vec_i(swi_vec), .nmi_i(nmi),
    .intr_i(intr), .intr_vec_i(intr_vec), .gate_trap_i(gate_trap),
    .sti_i(sti), .cli_i(cli), .iret_i(iret), .iret_if_i(iret_if),
    .take_o(take), .vec_o(vec), .err_valid_o(err_v), .cls_o(cls),
    .intr_ack_o(ack), .ie_o(ie)
  );

  typedef struct packed {
    logic          t;
    logic [VW-1:0] v;
    logic          e;
    logic [1:0]    c;
    logic          a;
    logic          ie;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;

  // staged stimulus
  logic          s_bnd, s_exc_v, s_swi_v, s_nmi, s_intr, s_gate, s_sti, s_cli, s_iret, s_iret_if;
  logic [2:0]    s_exc_c;
  logic [VW-1:0] s_swi_vec, s_intr_vec;

  task automatic clr();
    s_bnd = 0; s_exc_v = 0; s_swi_v = 0; s_nmi = 0; s_intr = 0; s_gate = 0;
    s_sti = 0; s_cli = 0; s_iret = 0; s_iret_if = 0; s_exc_c = '0;
    s_swi_vec = '0; s_intr_vec = '0;
  endtask

  task automatic apply();
    boundary = s_bnd; exc_v = s_exc_v; exc_c = s_exc_c; swi_v = s_swi_v;
    swi_vec = s_swi_vec; nmi = s_nmi; intr = s_intr; intr_vec = s_intr_vec;
    gate_trap = s_gate; sti = s_sti; cli = s_cli; iret = s_iret; iret_if = s_iret_if;
  endtask

  // driver: one cycle of stimulus plus its expected result
  task automatic go(string tag, logic t, logic [VW-1:0] v, logic e, logic [1:0] c,
                    logic a, logic ie_exp);
    exp_t x;
    @(negedge clk);
    apply();
    x.t = t; x.v = v; x.e = e; x.c = c; x.a = a; x.ie = ie_exp;
    exp_q.push_back(x);
    tag_q.push_back(tag);
    clr();
  endtask

  task automatic miss(string tag, logic ie_exp);
    go(tag, 1'b0, '0, 1'b0, 2'b00, 1'b0, ie_exp);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t x, got;
        string tg;
        x  = exp_q.pop_front();
        tg = tag_q.pop_front();
        got.t = take; got.e = err_v; got.a = ack; got.ie = ie;
        got.v = take ? vec : '0;
        got.c = take ? cls : 2'b00;
        n_cmp++;
        if (got !== x) begin
          n_bad++;
          $display("FAIL %s: take=%0b vec=%0d err=%0b cls=%0d ack=%0b ie=%0b, expected take=%0b vec=%0d err=%0b cls=%0d ack=%0b ie=%0b",
                   tg, got.t, got.v, got.e, got.c, got.a, got.ie,
                   x.t, x.v, x.e, x.c, x.a, x.ie);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clr(); apply();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    miss("R1 reset idle", 1'b0);
    // R6 masked while flag clear
    s_intr = 1; s_bnd = 1; s_intr_vec = 8'h40; miss("R6 masked ie=0", 1'b0);
    s_sti = 1; miss("R9 sti", 1'b0);
    // R6 off boundary
    s_intr = 1; s_bnd = 0; s_intr_vec = 8'h40; miss("R6 no boundary", 1'b1);
    s_intr = 1; s_bnd = 1; s_intr_vec = 8'h40; s_gate = 1;
    go("R6 maskable taken", 1, 8'h40, 0, 2'b10, 1, 1'b1);
    // R2/R3 GP, interrupt gate clears flag
    s_exc_v = 1; s_exc_c = 3'd4; s_gate = 0; go("R3 gp err", 1, 8'd13, 1, 2'b00, 0, 1'b1);
    miss("R10 int gate cleared", 1'b0);
    s_sti = 1; miss("R9 sti again", 1'b0);
    // R5 priority
    s_exc_v = 1; s_exc_c = 3'd0; s_swi_v = 1; s_swi_vec = 8'h80;
    s_intr = 1; s_bnd = 1; s_intr_vec = 8'h41; s_gate = 1;
    go("R5 exc first", 1, 8'd0, 0, 2'b00, 0, 1'b1);
    s_swi_v = 1; s_swi_vec = 8'h80; s_intr = 1; s_bnd = 1; s_intr_vec = 8'h41; s_gate = 1;
    go("R5 swi over intr", 1, 8'h80, 0, 2'b01, 0, 1'b1);
    s_exc_v = 1; s_exc_c = 3'd7; s_gate = 1; go("R2 breakpoint", 1, 8'd3, 0, 2'b01, 0, 1'b1);
    s_exc_v = 1; s_exc_c = 3'd5; s_gate = 1; go("R2 page", 1, 8'd14, 1, 2'b00, 0, 1'b1);
    s_exc_v = 1; s_exc_c = 3'd6; s_gate = 1; go("R3 machine check", 1, 8'd18, 0, 2'b00, 0, 1'b1);
    s_exc_v = 1; s_exc_c = 3'd1; s_gate = 1; go("R2 invalid op", 1, 8'd6, 0, 2'b00, 0, 1'b1);
    s_exc_v = 1; s_exc_c = 3'd2; s_gate = 1; go("R2 not present", 1, 8'd11, 1, 2'b00, 0, 1'b1);
    s_exc_v = 1; s_exc_c = 3'd3; s_gate = 1; go("R2 stack", 1, 8'd12, 1, 2'b00, 0, 1'b1);
    s_cli = 1; miss("R9 cli", 1'b1);
    miss("R9 cli effect", 1'b0);
    // R7/R8 non-maskable
    s_nmi = 1; miss("R7 latch delay", 1'b0);
    s_intr = 1; s_bnd = 1; s_intr_vec = 8'h42;
    go("R7 nmi ie=0", 1, 8'd2, 0, 2'b10, 0, 1'b0);
    s_nmi = 1; s_swi_v = 1; s_swi_vec = 8'h21; miss("R8 swi blocked", 1'b0);
    s_exc_v = 1; s_exc_c = 3'd4; miss("R8 exc blocked", 1'b0);
    s_iret = 1; s_iret_if = 1; miss("R8 iret cycle", 1'b0);
    s_gate = 1; go("R8 second nmi", 1, 8'd2, 0, 2'b10, 0, 1'b1);
    s_iret = 1; s_iret_if = 0; miss("R11 iret blocked", 1'b1);
    miss("R11 restored 0", 1'b0);
    s_swi_v = 1; s_swi_vec = 8'hFF; s_gate = 1; go("R4 swi 255", 1, 8'hFF, 0, 2'b01, 0, 1'b0);
    s_swi_v = 1; s_swi_vec = 8'h0D; s_gate = 1; go("R4 swi 13 no err", 1, 8'h0D, 0, 2'b01, 0, 1'b0);
    // R11 precedence
    s_sti = 1; s_iret = 1; s_iret_if = 0; miss("R11 iret over sti", 1'b0);
    miss("R11 iret over sti effect", 1'b0);
    s_sti = 1; miss("R9 sti third", 1'b0);
    s_swi_v = 1; s_swi_vec = 8'h30; s_gate = 0; s_sti = 1;
    go("R11 gate over sti", 1, 8'h30, 0, 2'b01, 0, 1'b1);
    miss("R10 gate over sti effect", 1'b0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule